// File: doc/BRIEF.md
# Single-Stream DMA Transfer Engine

This block copies data items on its own, so the processor does not have to. Software sets a fixed peripheral address, one or two memory base addresses and an item count through a small register port, then writes the enable bit. Each item is read from its source address and then written to its destination address on a simple bus port. The bus returns read data in the same cycle. A level request from the peripheral paces the transfers that involve a peripheral. A memory-to-memory copy runs without waiting for a request.

There are three run modes. A one-shot run stops after the programmed count. A looping run returns to its start after each pass and keeps going. A ping-pong run switches between two memory buffers at the end of each pass, so software can work on one buffer while the other fills. Each finished pass sets a sticky completion flag, and that flag drives the interrupt line when its enable is set. The configuration can be changed only while the stream is stopped. Software must see the enable bit read back as zero before it reprograms anything.

Top module: `dma_stream`

## Requirements
- R1: After reset, every register reads zero, `irq_o` is low and the bus port is idle.
- R2: In one-shot mode (mode field 0) the stream moves exactly the programmed number of items, then sets the completion flag (status bit 0) and its enable bit (CTRL bit 0) reads 0.
- R3: The direction field (CTRL bits 2:1) selects source and destination. Value 0 reads the peripheral address and writes memory. Value 1 reads memory and writes the peripheral address. Value 2 copies from the peripheral-address register, used as a memory source, into memory. Each item is one read cycle followed by one write cycle.
- R4: For direction 0 or 1, an item starts only while `req_i` is high, and `ack_o` pulses once per item. Direction 2 never waits for `req_i`.
- R5: With the increment bit (CTRL bit 3) set, the memory address steps by the item size in bytes after each item. With it clear, the memory address stays fixed. The peripheral address never changes.
- R6: The size bit (CTRL bit 4) selects the item size: 0 moves one byte, 1 moves two bytes, little-endian. `bus_wide_o` follows this bit.
- R7: In looping mode (mode field 1, CTRL bits 6:5), after the last item the count and memory address return to their programmed values and transfers go on with no software write.
- R8: In ping-pong mode (mode field 2) the first pass uses memory base 0. Each pass then ends by switching to the other base and reloading the count. Status bit 1 shows the buffer in use and toggles at each completion.
- R9: The completion flag is sticky. Writing 1 to bit 0 of the flag-clear register (offset 6) clears it. If a completion and a clear fall in the same cycle, the completion wins. `irq_o` is the flag ANDed with the interrupt enable (CTRL bit 7).
- R10: While the stream is enabled, writes to the peripheral address (offset 1), memory bases (offsets 2, 3), count (offset 4) and the configuration bits of CTRL (offset 0) are ignored.
- R11: Writing CTRL with bit 0 clear while the stream is enabled stops it after the item in progress. No further bus cycles follow. While enabled, the count register reads the number of items remaining.
- R12: Writing the enable bit while the count register is zero does not start the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | W | Register write data |
| reg_rdata_o | output | W | Register read data (combinational) |
| req_i | input | 1 | Peripheral transfer request (level) |
| ack_o | output | 1 | One-cycle pulse per completed peripheral item |
| bus_req_o | output | 1 | Bus cycle valid |
| bus_we_o | output | 1 | Bus cycle is a write |
| bus_wide_o | output | 1 | Bus cycle is two bytes |
| bus_addr_o | output | W | Bus byte address |
| bus_wdata_o | output | 16 | Bus write data |
| bus_rdata_i | input | 16 | Bus read data, valid in the read cycle |
| irq_o | output | 1 | Completion interrupt |

## Verification
A write of 1 to the flag-clear register can land on the same clock edge as the write cycle of a pass's last item. That edge is the one that sets the completion flag. The bench provokes this with a one-item memory-to-memory run. It watches `bus_we_o` at the falling edge and drives the clear write across the next rising edge. The run is judged correct if status bit 0 and `irq_o` both read 1 afterwards. Ping-pong mode also has two events that fall together: the buffer toggle and the last write of a pass. The bench checks this by reading status bit 1 right after the log of write addresses shows that pass's final write.

// File: rtl/dma_stream_pkg.sv
package dma_stream_pkg;

  typedef enum logic [1:0] {
    DIR_P2M = 2'd0,
    DIR_M2P = 2'd1,
    DIR_M2M = 2'd2
  } dir_e;

  typedef enum logic [1:0] {
    MODE_ONCE = 2'd0,
    MODE_CIRC = 2'd1,
    MODE_DBUF = 2'd2
  } mode_e;

  localparam logic [2:0] OFF_CTRL   = 3'd0;
  localparam logic [2:0] OFF_PADDR  = 3'd1;
  localparam logic [2:0] OFF_MADDR0 = 3'd2;
  localparam logic [2:0] OFF_MADDR1 = 3'd3;
  localparam logic [2:0] OFF_COUNT  = 3'd4;
  localparam logic [2:0] OFF_STATUS = 3'd5;
  localparam logic [2:0] OFF_FCLR   = 3'd6;

  // occupies CTRL[7:1]
  typedef struct packed {
    logic  tcie;
    mode_e mode;
    logic  wide;
    logic  minc;
    dir_e  dir;
  } cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RD,
    ST_WR
  } st_e;

endpackage

// File: rtl/dma_stream_regs.sv
module dma_stream_regs
  import dma_stream_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [2:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic         active_i,
  input  logic         cur_buf_i,
  input  logic [W-1:0] cnt_rem_i,
  input  logic         tc_set_i,
  output cfg_t         cfg_o,
  output logic [W-1:0] paddr_o,
  output logic [W-1:0] maddr0_o,
  output logic [W-1:0] maddr1_o,
  output logic [W-1:0] count_o,
  output logic         start_o,
  output logic         stop_o,
  output logic         tc_flag_o
);

  cfg_t         cfg_q;
  logic [W-1:0] paddr_q, maddr0_q, maddr1_q, count_q;
  logic         tc_q;
  logic         cfg_wr;

  assign cfg_wr  = wr_i && !active_i;
  assign start_o = cfg_wr && (addr_i == OFF_CTRL) && wdata_i[0] && (count_q != '0);
  assign stop_o  = wr_i && active_i && (addr_i == OFF_CTRL) && !wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      paddr_q  <= '0;
      maddr0_q <= '0;
      maddr1_q <= '0;
      count_q  <= '0;
      tc_q     <= 1'b0;
    end else begin
      // completion beats a clear in the same cycle
      if (tc_set_i)                                         tc_q <= 1'b1;
      else if (wr_i && (addr_i == OFF_FCLR) && wdata_i[0])  tc_q <= 1'b0;
      if (cfg_wr) begin
        case (addr_i)
          OFF_CTRL:   cfg_q    <= cfg_t'(wdata_i[7:1]);
          OFF_PADDR:  paddr_q  <= wdata_i;
          OFF_MADDR0: maddr0_q <= wdata_i;
          OFF_MADDR1: maddr1_q <= wdata_i;
          OFF_COUNT:  count_q  <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_CTRL:   rdata_o[7:0] = {cfg_q, active_i};
      OFF_PADDR:  rdata_o = paddr_q;
      OFF_MADDR0: rdata_o = maddr0_q;
      OFF_MADDR1: rdata_o = maddr1_q;
      OFF_COUNT:  rdata_o = active_i ? cnt_rem_i : count_q;
      OFF_STATUS: rdata_o[1:0] = {cur_buf_i, tc_q};
      default: ;
    endcase
  end

  assign cfg_o     = cfg_q;
  assign paddr_o   = paddr_q;
  assign maddr0_o  = maddr0_q;
  assign maddr1_o  = maddr1_q;
  assign count_o   = count_q;
  assign tc_flag_o = tc_q;

endmodule

// File: rtl/dma_stream_agen.sv
module dma_stream_agen
  import dma_stream_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] madr_i,
  input  logic [W-1:0] cnt_i,
  input  logic         buf_i,
  input  logic         wide_i,
  input  logic         minc_i,
  input  mode_e        mode_i,
  input  logic [W-1:0] maddr0_i,
  input  logic [W-1:0] maddr1_i,
  input  logic [W-1:0] count_i,
  output logic [W-1:0] madr_o,
  output logic [W-1:0] cnt_o,
  output logic         buf_o,
  output logic         last_o
);

  logic [W-1:0] step;

  assign step   = wide_i ? W'(2) : W'(1);
  assign last_o = (cnt_i == W'(1));

  always_comb begin
    madr_o = minc_i ? madr_i + step : madr_i;
    cnt_o  = cnt_i - W'(1);
    buf_o  = buf_i;
    if (last_o) begin
      case (mode_i)
        MODE_CIRC: begin
          madr_o = maddr0_i;
          cnt_o  = count_i;
        end
        MODE_DBUF: begin
          buf_o  = ~buf_i;
          madr_o = buf_i ? maddr0_i : maddr1_i;
          cnt_o  = count_i;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dma_stream_xfer.sv
module dma_stream_xfer
  import dma_stream_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  cfg_t         cfg_i,
  input  logic [W-1:0] paddr_i,
  input  logic [W-1:0] maddr0_i,
  input  logic [W-1:0] maddr1_i,
  input  logic [W-1:0] count_i,
  input  logic         start_i,
  input  logic         stop_i,
  input  logic         req_i,
  input  logic [15:0]  bus_rdata_i,
  output logic         bus_req_o,
  output logic         bus_we_o,
  output logic [W-1:0] bus_addr_o,
  output logic [15:0]  bus_wdata_o,
  output logic         ack_o,
  output logic         active_o,
  output logic         cur_buf_o,
  output logic [W-1:0] cnt_rem_o,
  output logic         tc_set_o
);

  st_e          st_q;
  logic [W-1:0] cnt_q, madr_q, madr_nx, cnt_nx;
  logic         buf_q, buf_nx, last;
  logic         stop_q;
  logic [15:0]  data_q;
  logic         is_m2m, go;
  logic [W-1:0] src, dst;

  assign is_m2m = (cfg_i.dir != DIR_P2M) && (cfg_i.dir != DIR_M2P);
  assign go     = is_m2m || req_i;
  assign src    = (cfg_i.dir == DIR_M2P) ? madr_q : paddr_i;
  assign dst    = (cfg_i.dir == DIR_M2P) ? paddr_i : madr_q;

  dma_stream_agen #(.W(W)) u_agen (
    .madr_i   (madr_q),
    .cnt_i    (cnt_q),
    .buf_i    (buf_q),
    .wide_i   (cfg_i.wide),
    .minc_i   (cfg_i.minc),
    .mode_i   (cfg_i.mode),
    .maddr0_i (maddr0_i),
    .maddr1_i (maddr1_i),
    .count_i  (count_i),
    .madr_o   (madr_nx),
    .cnt_o    (cnt_nx),
    .buf_o    (buf_nx),
    .last_o   (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      madr_q <= '0;
      buf_q  <= 1'b0;
      stop_q <= 1'b0;
      data_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_WAIT;
          cnt_q  <= count_i;
          madr_q <= maddr0_i;
          buf_q  <= 1'b0;
          stop_q <= 1'b0;
        end
        ST_WAIT: begin
          if (stop_i)  st_q <= ST_IDLE;
          else if (go) st_q <= ST_RD;
        end
        ST_RD: begin
          data_q <= bus_rdata_i;
          st_q   <= ST_WR;
          if (stop_i) stop_q <= 1'b1;
        end
        ST_WR: begin
          cnt_q  <= cnt_nx;
          madr_q <= madr_nx;
          buf_q  <= buf_nx;
          if ((last && cfg_i.mode != MODE_CIRC && cfg_i.mode != MODE_DBUF) || stop_q || stop_i)
            st_q <= ST_IDLE;
          else
            st_q <= ST_WAIT;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_req_o   = (st_q == ST_RD) || (st_q == ST_WR);
  assign bus_we_o    = (st_q == ST_WR);
  assign bus_addr_o  = (st_q == ST_WR) ? dst : src;
  assign bus_wdata_o = cfg_i.wide ? data_q : {8'h00, data_q[7:0]};
  assign ack_o       = (st_q == ST_WR) && !is_m2m;
  assign tc_set_o    = (st_q == ST_WR) && last;
  assign active_o    = (st_q != ST_IDLE);
  assign cur_buf_o   = buf_q;
  assign cnt_rem_o   = cnt_q;

endmodule

// File: rtl/dma_stream.sv
module dma_stream
  import dma_stream_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         reg_we_i,
  input  logic [2:0]   reg_addr_i,
  input  logic [W-1:0] reg_wdata_i,
  output logic [W-1:0] reg_rdata_o,
  input  logic         req_i,
  output logic         ack_o,
  output logic         bus_req_o,
  output logic         bus_we_o,
  output logic         bus_wide_o,
  output logic [W-1:0] bus_addr_o,
  output logic [15:0]  bus_wdata_o,
  input  logic [15:0]  bus_rdata_i,
  output logic         irq_o
);

  cfg_t         cfg;
  logic [W-1:0] paddr, maddr0, maddr1, count, cnt_rem;
  logic         start, stop, active, cur_buf, tc_set, tc_flag;

  dma_stream_regs #(.W(W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .active_i  (active),
    .cur_buf_i (cur_buf),
    .cnt_rem_i (cnt_rem),
    .tc_set_i  (tc_set),
    .cfg_o     (cfg),
    .paddr_o   (paddr),
    .maddr0_o  (maddr0),
    .maddr1_o  (maddr1),
    .count_o   (count),
    .start_o   (start),
    .stop_o    (stop),
    .tc_flag_o (tc_flag)
  );

  dma_stream_xfer #(.W(W)) u_xfer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_i       (cfg),
    .paddr_i     (paddr),
    .maddr0_i    (maddr0),
    .maddr1_i    (maddr1),
    .count_i     (count),
    .start_i     (start),
    .stop_i      (stop),
    .req_i       (req_i),
    .bus_rdata_i (bus_rdata_i),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .ack_o       (ack_o),
    .active_o    (active),
    .cur_buf_o   (cur_buf),
    .cnt_rem_o   (cnt_rem),
    .tc_set_o    (tc_set)
  );

  assign bus_wide_o = cfg.wide;
  assign irq_o      = tc_flag && cfg.tcie;

endmodule

// File: rtl/dma_stream_chk.sv
module dma_stream_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         bus_req_i,
  input logic         bus_we_i,
  input logic         ack_i,
  input logic         active_i,
  input logic         cur_buf_i,
  input logic         tc_flag_i,
  input logic [W-1:0] paddr_i,
  input logic [W-1:0] maddr0_i
);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> !bus_req_i);

  p_rd_then_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i) |=> (bus_req_i && bus_we_i));

  p_ack_on_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |-> (bus_req_i && bus_we_i));

  p_tc_after_item_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tc_flag_i) |-> $past(bus_req_i && bus_we_i));

  p_cfg_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(active_i) |-> ($stable(paddr_i) && $stable(maddr0_i)));

  p_buf_flip_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(active_i) && !$stable(cur_buf_i)) |-> $past(bus_req_i && bus_we_i));

endmodule

bind dma_stream dma_stream_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bus_req_i (bus_req_o),
  .bus_we_i  (bus_we_o),
  .ack_i     (ack_o),
  .active_i  (active),
  .cur_buf_i (cur_buf),
  .tc_flag_i (tc_flag),
  .paddr_i   (paddr),
  .maddr0_i  (maddr0)
);

// File: tb/dma_stream_bench.sv
module dma_stream_bench;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_we = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         req = 1'b0;
  logic         ack, bus_req, bus_we, bus_wide, irq;
  logic [W-1:0] bus_addr;
  logic [15:0]  bus_wdata, bus_rdata;

  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  dma_stream #(.W(W)) u_dma_stream (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (reg_we),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .req_i       (req),
    .ack_o       (ack),
    .bus_req_o   (bus_req),
    .bus_we_o    (bus_we),
    .bus_wide_o  (bus_wide),
    .bus_addr_o  (bus_addr),
    .bus_wdata_o (bus_wdata),
    .bus_rdata_i (bus_rdata),
    .irq_o       (irq)
  );

  // memory model, write-address log, activity counters
  logic [7:0]  mem [0:255];
  logic [7:0]  exp_mem [0:255];
  logic [15:0] wlog [0:15];
  int          nlog = 0, nbus = 0, nack = 0;
  logic        init_go = 1'b0;
  logic [7:0]  init_seed = '0;

  assign bus_rdata = {mem[bus_addr[7:0] + 8'd1], mem[bus_addr[7:0]]};

  always @(posedge clk) begin
    if (init_go) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ init_seed;
      nlog <= 0; nbus <= 0; nack <= 0;
    end else begin
      if (bus_req) nbus <= nbus + 1;
      if (ack) nack <= nack + 1;
      if (bus_req && bus_we) begin
        mem[bus_addr[7:0]] <= bus_wdata[7:0];
        if (bus_wide) mem[bus_addr[7:0] + 8'd1] <= bus_wdata[15:8];
        if (nlog < 16) wlog[nlog] <= bus_addr;
        nlog <= nlog + 1;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [W-1:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [W-1:0] v;
    for (int i = 0; i < 3000; i++) begin
      reg_rd(3'd0, v);
      if (!v[0]) break;
    end
  endtask

  task automatic mem_init(input logic [7:0] seed);
    @(negedge clk); init_go = 1'b1; init_seed = seed;
    @(negedge clk); init_go = 1'b0;
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i) ^ seed;
  endtask

  function automatic logic [W-1:0] ctrl(input logic tcie, input logic [1:0] mode,
      input logic wide, input logic minc, input logic [1:0] dir, input logic en);
    return W'({tcie, mode, wide, minc, dir, en});
  endfunction

  // [31:30] dir [29] minc [28] wide [27:24] count [23:16] paddr [15:8] maddr [7:0] seed
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    {2'd0, 1'b1, 1'b1, 4'd4, 8'h80, 8'h10, 8'h5A},
    {2'd0, 1'b0, 1'b0, 4'd3, 8'h81, 8'h20, 8'h33},
    {2'd1, 1'b1, 1'b0, 4'd5, 8'h90, 8'h30, 8'hC1},
    {2'd1, 1'b1, 1'b1, 4'd2, 8'h92, 8'h40, 8'h0F},
    {2'd2, 1'b1, 1'b1, 4'd3, 8'hA0, 8'h50, 8'h77},
    {2'd2, 1'b0, 1'b0, 4'd1, 8'hA4, 8'h60, 8'hE8}
  };

  initial begin
    #(8 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    int mism, n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_rd(3'd0, v); check("R1 ctrl", v, 0);
    reg_rd(3'd4, v); check("R1 count", v, 0);
    reg_rd(3'd5, v); check("R1 status", v, 0);
    check("R1 irq", irq, 0);
    check("R1 bus", bus_req, 0);

    // vector table: one-shot runs
    for (int k = 0; k < NV; k++) begin
      logic [1:0] dir;
      logic       minc, wide;
      logic [7:0] cnt, pa, ma, st, ds, m;
      dir = VEC[k][31:30]; minc = VEC[k][29]; wide = VEC[k][28];
      cnt = 8'(VEC[k][27:24]); pa = VEC[k][23:16]; ma = VEC[k][15:8];
      mem_init(VEC[k][7:0]);
      req = 1'b1;
      reg_wr(3'd1, W'(pa));
      reg_wr(3'd2, W'(ma));
      reg_wr(3'd4, W'(cnt));
      reg_wr(3'd0, ctrl(1'b1, 2'd0, wide, minc, dir, 1'b1));
      wait_idle();
      req = 1'b0;
      for (int i = 0; i < int'(cnt); i++) begin
        m  = minc ? ma + 8'(i * (wide ? 2 : 1)) : ma;
        st = (dir == 2'd1) ? m : pa;
        ds = (dir == 2'd1) ? pa : m;
        exp_mem[ds] = exp_mem[st];
        if (wide) exp_mem[ds + 8'd1] = exp_mem[st + 8'd1];
      end
      mism = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) mism++;
      check($sformatf("R3 R5 R6 vector %0d mismatching bytes", k), mism, 0);
      check($sformatf("R2 vector %0d items", k), nlog, int'(cnt));
      reg_rd(3'd0, v); check("R2 enable cleared", v[0], 0);
      check("R2 R9 irq after pass", irq, 1);
      if (dir != 2'd2) check("R4 ack per item", nack, int'(cnt));
    end

    // R9 clear
    reg_wr(3'd6, 16'h0001);
    check("R9 irq after clear", irq, 0);
    reg_rd(3'd5, v); check("R9 flag after clear", v[0], 0);

    // R9 interrupt enable gates irq only
    mem_init(8'h11);
    reg_wr(3'd4, 16'd1);
    reg_wr(3'd0, ctrl(1'b0, 2'd0, 1'b0, 1'b0, 2'd2, 1'b1));
    wait_idle();
    reg_rd(3'd5, v); check("R9 flag without irq enable", v[0], 1);
    check("R9 irq masked", irq, 0);
    reg_wr(3'd6, 16'h0001);

    // R4 request gating
    mem_init(8'h22);
    req = 1'b0;
    reg_wr(3'd1, 16'h0080);
    reg_wr(3'd2, 16'h0010);
    reg_wr(3'd4, 16'd2);
    reg_wr(3'd0, ctrl(1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 1'b1));
    repeat (10) @(negedge clk);
    check("R4 no bus cycle without request", nbus, 0);
    reg_rd(3'd4, v); check("R11 remaining count", v, 2);
    req = 1'b1;
    wait_idle();
    req = 1'b0;
    check("R4 acks after request", nack, 2);

    // R12 zero count
    mem_init(8'h44);
    reg_wr(3'd4, 16'd0);
    reg_wr(3'd0, ctrl(1'b0, 2'd0, 1'b0, 1'b1, 2'd2, 1'b1));
    reg_rd(3'd0, v); check("R12 not started", v[0], 0);
    repeat (5) @(negedge clk);
    check("R12 no bus cycles", nbus, 0);

    // R7 looping mode, R10 frozen writes, R11 stop
    mem_init(8'h55);
    reg_wr(3'd1, 16'h00A0);
    reg_wr(3'd2, 16'h0040);
    reg_wr(3'd4, 16'd2);
    reg_wr(3'd0, ctrl(1'b0, 2'd1, 1'b0, 1'b1, 2'd2, 1'b1));
    for (int i = 0; i < 2000 && nlog < 5; i++) @(negedge clk);
    mism = 0;
    for (int i = 0; i < 5; i++) if (wlog[i] !== ((i % 2 == 0) ? 16'h0040 : 16'h0041)) mism++;
    check("R7 loop write addresses", mism, 0);
    reg_rd(3'd0, v); check("R7 still enabled", v[0], 1);
    reg_wr(3'd1, 16'h0011);
    reg_wr(3'd2, 16'h0022);
    reg_wr(3'd0, 16'h0000);
    wait_idle();
    reg_rd(3'd1, v); check("R10 peripheral address kept", v, 16'h00A0);
    reg_rd(3'd2, v); check("R10 memory base kept", v, 16'h0040);
    reg_rd(3'd0, v); check("R10 config kept", v, ctrl(1'b0, 2'd1, 1'b0, 1'b1, 2'd2, 1'b0));
    n0 = nlog;
    repeat (10) @(negedge clk);
    check("R11 no writes after stop", nlog, n0);
    reg_wr(3'd6, 16'h0001);

    // R8 ping-pong
    mem_init(8'h66);
    reg_wr(3'd3, 16'h0060);
    reg_wr(3'd0, ctrl(1'b0, 2'd2, 1'b0, 1'b1, 2'd2, 1'b1));
    for (int i = 0; i < 2000 && nlog < 2; i++) @(negedge clk);
    reg_rd(3'd5, v); check("R8 buffer bit after first pass", v[1], 1);
    for (int i = 0; i < 2000 && nlog < 4; i++) @(negedge clk);
    reg_rd(3'd5, v); check("R8 buffer bit after second pass", v[1], 0);
    for (int i = 0; i < 2000 && nlog < 6; i++) @(negedge clk);
    mism = 0;
    if (wlog[0] !== 16'h0040) mism++;
    if (wlog[1] !== 16'h0041) mism++;
    if (wlog[2] !== 16'h0060) mism++;
    if (wlog[3] !== 16'h0061) mism++;
    if (wlog[4] !== 16'h0040) mism++;
    if (wlog[5] !== 16'h0041) mism++;
    check("R8 ping-pong write addresses", mism, 0);
    reg_wr(3'd0, 16'h0000);
    wait_idle();
    reg_wr(3'd6, 16'h0001);

    // R9 clear and completion on the same edge
    mem_init(8'h77);
    reg_wr(3'd4, 16'd1);
    reg_wr(3'd0, ctrl(1'b1, 2'd0, 1'b0, 1'b0, 2'd2, 1'b1));
    for (int i = 0; i < 50 && !bus_we; i++) @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd6; reg_wdata = 16'h0001;
    @(negedge clk);
    reg_we = 1'b0;
    reg_rd(3'd5, v); check("R9 set wins over clear", v[0], 1);
    check("R9 irq after collision", irq, 1);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule